// File: doc/BRIEF.md
# OSD Character Raster Timing Generator

This block follows the incoming horizontal and vertical sync of a display and turns them into the character-cell coordinates of an on-screen overlay. The overlay is a 10-row by 24-column grid of character cells. Each cell is 12 dots wide and shows a font glyph that is 18 lines tall. For every dot clock the block gives the display-RAM address of the cell under the beam, plus the font line and font dot inside that glyph. A font ROM and a colour stage placed after it use these to paint the pixel.

Software sets several things. It picks the active level of each sync input. It places the overlay origin with a dot offset and a line offset. It sets the vertical cell height anywhere from 18 to 71 scan lines, so the glyph keeps its proportions at different line rates. The 18 font lines are spread over that height with a running accumulator, with no divider. Double width makes each cell 24 dots, with every font dot shown for two dot clocks. Double height makes each cell twice the programmed height, with every font line step lasting two scan lines. Either mode can be used alone or both together. A global enable gates the display-active output.

Top module: `osd_raster_gen`

## Requirements
- R1: While reset is held, dispActive, ramAddr, fontLine and fontDot are all 0.
- R2: With hSyncPol = 1 the horizontal input counts as active when low, and with vSyncPol = 1 the same holds for the vertical input. With pol = 0 an input is active when high. Inverting an input together with its pol bit gives the same outputs.
- R3: The dot position p is 0 in the clock period that begins at the second rising clock edge after the horizontal input becomes active. p then rises by 1 each clock. The line number l is 0 on the line where the vertical input becomes active, and rises by 1 at each later horizontal activation.
- R4: Horizontally, the overlay covers the positions from hStart to hStart + 24*W - 1, where W is 12, or 24 with dblWidth = 1. The column is (p - hStart) / W.
- R5: fontDot is (p - hStart) mod 12 with dblWidth = 0, and ((p - hStart) mod 24) / 2 with dblWidth = 1.
- R6: Vertically, the overlay covers 10 rows starting at line vStart. Each row is C lines tall, where C is the effective height H, or 2H with dblHeight = 1. The row is (l - vStart) / C.
- R7: With s = (l - vStart) mod C and t = s (single height), fontLine is floor(t * 18 / H) and stays in 0..17.
- R8: The effective height H is charHeight clamped to the range 18..71. Values below 18 act as 18, and values above 71 act as 71.
- R9: With dblHeight = 1, t = s / 2, so each font line step lasts two scan lines.
- R10: dispActive is 1 only when osdEnable = 1 and the position lies inside both the horizontal region and the vertical region.
- R11: While dispActive is 1, ramAddr = row * 24 + column, which lies in 0..239.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low synchronous reset |
| hSyncIn | input | 1 | Horizontal sync from the display |
| vSyncIn | input | 1 | Vertical sync from the display |
| hSyncPol | input | 1 | 1: horizontal sync is active low |
| vSyncPol | input | 1 | 1: vertical sync is active low |
| osdEnable | input | 1 | Global overlay enable |
| hStart | input | 11 | Dot position of the first overlay column |
| vStart | input | 11 | Line number of the first overlay row |
| charHeight | input | 7 | Programmed cell height in scan lines (clamped to 18..71) |
| dblHeight | input | 1 | Double the cell height |
| dblWidth | input | 1 | Double the cell width |
| dispActive | output | 1 | Beam is inside the enabled overlay grid |
| ramAddr | output | 8 | Display-RAM cell address, row*24+column |
| fontLine | output | 5 | Font line 0..17 within the glyph |
| fontDot | output | 4 | Font dot 0..11 within the glyph |

## Verification
Long lines with short frames exercise the horizontal path. They compare a plain cell width against a doubled one and a zero dot offset against a large one, which shows whether column steps and dot repeats fall on the right clocks. Short lines with full frames exercise the vertical path. They use heights of exactly 18 and 71, out-of-range values that must clamp, odd heights such as 25 where the accumulator carries unevenly, and double height. These separate errors in the line mapping from errors in the row boundaries. Runs with inverted sync inputs and runs with the enable cleared each check one gating path. Seeded random frames then mix every setting.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

  localparam int NUM_COLS   = 24;
  localparam int NUM_ROWS   = 10;
  localparam int CELL_DOTS  = 12;
  localparam int FONT_LINES = 18;

  localparam int COL_W  = $clog2(NUM_COLS);
  localparam int ROW_W  = $clog2(NUM_ROWS);
  localparam int ADDR_W = $clog2(NUM_COLS * NUM_ROWS);
  localparam int FD_W   = $clog2(CELL_DOTS);
  localparam int FL_W   = $clog2(FONT_LINES);
  localparam int SUB_W  = $clog2(2 * CELL_DOTS);

  // Strobes from the sync control to the cell datapath
  typedef struct packed {
    logic lineStart;   // normalised horizontal sync rising edge
    logic frameStart;  // normalised vertical sync rising edge
    logic lineStep;    // either of the above
    logic hLoad;       // next dot position equals the horizontal origin
    logic vLoad;       // next line number equals the vertical origin
  } strobes_t;

endpackage

// File: rtl/osd_sync_ctrl.sv
module osd_sync_ctrl
  import osd_raster_pkg::*;
#(
  parameter int DOT_W  = 11,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              hSyncPol,
  input  logic              vSyncPol,
  input  logic [DOT_W-1:0]  hStart,
  input  logic [LINE_W-1:0] vStart,
  output strobes_t          strobes
);

  localparam logic [DOT_W-1:0]  DOT_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic hsNorm, hsPrev, vsNorm, vsPrev;
  logic hRise, vRise, lineStep;
  logic [DOT_W-1:0]  hCount, hNext;
  logic [LINE_W-1:0] lineCnt, lineNext;

  // Sample and normalise both syncs to active-high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsNorm <= 1'b0;
      hsPrev <= 1'b0;
      vsNorm <= 1'b0;
      vsPrev <= 1'b0;
    end else begin
      hsNorm <= hSyncIn ^ hSyncPol;
      hsPrev <= hsNorm;
      vsNorm <= vSyncIn ^ vSyncPol;
      vsPrev <= vsNorm;
    end
  end

  assign hRise    = hsNorm & ~hsPrev;
  assign vRise    = vsNorm & ~vsPrev;
  assign lineStep = hRise | vRise;

  always_comb begin
    if (hRise)                hNext = '0;
    else if (hCount == DOT_MAX) hNext = hCount;
    else                      hNext = hCount + DOT_W'(1);

    if (vRise)                   lineNext = '0;
    else if (lineCnt == LINE_MAX) lineNext = lineCnt;
    else                         lineNext = lineCnt + LINE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount  <= '0;
      lineCnt <= '0;
    end else begin
      hCount <= hNext;
      if (lineStep) lineCnt <= lineNext;
    end
  end

  always_comb begin
    strobes.lineStart  = hRise;
    strobes.frameStart = vRise;
    strobes.lineStep   = lineStep;
    strobes.hLoad      = (hNext == hStart) && (hRise || hNext != hCount);
    strobes.vLoad      = lineStep && (lineNext == vStart) &&
                         (vRise || lineNext != lineCnt);
  end

  // R3: the dot position restarts from 0 after every line start
  a_r3_dot_origin: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.lineStart) |-> hCount == '0);

  // R3: the line number restarts from 0 after every frame start
  a_r3_line_origin: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.frameStart) |-> lineCnt == '0);

endmodule

// File: rtl/osd_cell_datapath.sv
module osd_cell_datapath
  import osd_raster_pkg::*;
#(
  parameter int HGT_W = 7,
  parameter int MIN_H = 18,
  parameter int MAX_H = 71
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [HGT_W-1:0]  charHeight,
  input  logic              dblHeight,
  input  logic              dblWidth,
  output logic              hActive,
  output logic              vActive,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [FL_W-1:0]   fontLine,
  output logic [FD_W-1:0]   fontDot
);

  localparam int ACC_W = HGT_W + 1;

  logic [SUB_W-1:0] dotSub, cellLast;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [HGT_W-1:0] hEff, tLine;
  logic [ACC_W-1:0] acc, accSum;
  logic [FL_W-1:0]  fLine;
  logic             phase;

  // Horizontal: dot within cell, column within row
  assign cellLast = dblWidth ? SUB_W'(2 * CELL_DOTS - 1) : SUB_W'(CELL_DOTS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hActive <= 1'b0;
      dotSub  <= '0;
      col     <= '0;
    end else if (strobes.hLoad) begin
      hActive <= 1'b1;
      dotSub  <= '0;
      col     <= '0;
    end else if (strobes.lineStart) begin
      hActive <= 1'b0;
    end else if (hActive) begin
      if (dotSub == cellLast) begin
        dotSub <= '0;
        if (col == COL_W'(NUM_COLS - 1)) hActive <= 1'b0;
        else                             col <= col + COL_W'(1);
      end else begin
        dotSub <= dotSub + SUB_W'(1);
      end
    end
  end

  assign fontDot = dblWidth ? FD_W'(dotSub >> 1) : FD_W'(dotSub);

  // Vertical: effective height, line accumulator, row counter
  always_comb begin
    if (charHeight < HGT_W'(MIN_H))      hEff = HGT_W'(MIN_H);
    else if (charHeight > HGT_W'(MAX_H)) hEff = HGT_W'(MAX_H);
    else                                 hEff = charHeight;
  end

  assign accSum = acc + ACC_W'(FONT_LINES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vActive <= 1'b0;
      row     <= '0;
      tLine   <= '0;
      acc     <= '0;
      fLine   <= '0;
      phase   <= 1'b0;
    end else if (strobes.lineStep) begin
      if (strobes.vLoad) begin
        vActive <= 1'b1;
        row     <= '0;
        tLine   <= '0;
        acc     <= '0;
        fLine   <= '0;
        phase   <= 1'b0;
      end else if (strobes.frameStart) begin
        vActive <= 1'b0;
      end else if (vActive) begin
        if (dblHeight && !phase) begin
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          if (tLine == hEff - HGT_W'(1)) begin
            tLine <= '0;
            acc   <= '0;
            fLine <= '0;
            if (row == ROW_W'(NUM_ROWS - 1)) vActive <= 1'b0;
            else                             row <= row + ROW_W'(1);
          end else begin
            tLine <= tLine + HGT_W'(1);
            if (accSum >= ACC_W'(hEff)) begin
              acc   <= accSum - ACC_W'(hEff);
              fLine <= fLine + FL_W'(1);
            end else begin
              acc <= accSum;
            end
          end
        end
      end
    end
  end

  assign fontLine = fLine;
  assign ramAddr  = ADDR_W'(row) * ADDR_W'(NUM_COLS) + ADDR_W'(col);

  // R4: inside a line the column only holds or steps by one
  a_r4_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (hActive && $past(hActive) && !$past(strobes.hLoad)) |->
      (col == $past(col) || col == $past(col) + COL_W'(1)));

  // R5: the font dot never leaves the glyph
  a_r5_dot_range: assert property (@(posedge clk) disable iff (!rstN)
    hActive |-> fontDot < FD_W'(CELL_DOTS));

  // R6: the row never leaves the grid
  a_r6_row_range: assert property (@(posedge clk) disable iff (!rstN)
    vActive |-> row < ROW_W'(NUM_ROWS));

  // R7: the font line never leaves the glyph
  a_r7_line_range: assert property (@(posedge clk) disable iff (!rstN)
    vActive |-> fLine < FL_W'(FONT_LINES));

  // R7: the font line holds, steps by one, or restarts at a new row
  a_r7_line_step: assert property (@(posedge clk) disable iff (!rstN)
    (vActive && $past(vActive) && !$past(strobes.vLoad)) |->
      (fLine == $past(fLine) || fLine == $past(fLine) + FL_W'(1) || fLine == '0));

endmodule

// File: rtl/osd_raster_gen.sv
module osd_raster_gen
  import osd_raster_pkg::*;
#(
  parameter int DOT_W  = 11,
  parameter int LINE_W = 11,
  parameter int HGT_W  = 7,
  parameter int MIN_H  = 18,
  parameter int MAX_H  = 71
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              hSyncPol,
  input  logic              vSyncPol,
  input  logic              osdEnable,
  input  logic [DOT_W-1:0]  hStart,
  input  logic [LINE_W-1:0] vStart,
  input  logic [HGT_W-1:0]  charHeight,
  input  logic              dblHeight,
  input  logic              dblWidth,
  output logic              dispActive,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [FL_W-1:0]   fontLine,
  output logic [FD_W-1:0]   fontDot
);

  strobes_t strobes;
  logic     hActive, vActive;

  osd_sync_ctrl #(.DOT_W(DOT_W), .LINE_W(LINE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hSyncIn  (hSyncIn),
    .vSyncIn  (vSyncIn),
    .hSyncPol (hSyncPol),
    .vSyncPol (vSyncPol),
    .hStart   (hStart),
    .vStart   (vStart),
    .strobes  (strobes)
  );

  osd_cell_datapath #(.HGT_W(HGT_W), .MIN_H(MIN_H), .MAX_H(MAX_H)) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .charHeight (charHeight),
    .dblHeight  (dblHeight),
    .dblWidth   (dblWidth),
    .hActive    (hActive),
    .vActive    (vActive),
    .ramAddr    (ramAddr),
    .fontLine   (fontLine),
    .fontDot    (fontDot)
  );

  assign dispActive = osdEnable & hActive & vActive;

  // R11: an active cell address always lies inside the grid
  a_r11_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    dispActive |-> ramAddr < ADDR_W'(NUM_COLS * NUM_ROWS));

endmodule

// File: tb/test_osd_raster_gen.sv
module test_osd_raster_gen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hSyncIn, vSyncIn, hSyncPol, vSyncPol, osdEnable;
  logic [10:0] hStart, vStart;
  logic [6:0]  charHeight;
  logic        dblHeight, dblWidth;
  logic        dispActive;
  logic [7:0]  ramAddr;
  logic [4:0]  fontLine;
  logic [3:0]  fontDot;

  int    checks = 0;
  int    errors = 0;
  int    lineIdx = 0;
  string ctx = "R3";

  always #2.5ns clk = ~clk;

  osd_raster_gen i_osd_raster_gen (
    .clk(clk), .rstN(rstN), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .hSyncPol(hSyncPol), .vSyncPol(vSyncPol), .osdEnable(osdEnable),
    .hStart(hStart), .vStart(vStart), .charHeight(charHeight),
    .dblHeight(dblHeight), .dblWidth(dblWidth), .dispActive(dispActive),
    .ramAddr(ramAddr), .fontLine(fontLine), .fontDot(fontDot)
  );

  function automatic int clampHeight(input int h);
    if (h < 18) return 18;
    if (h > 71) return 71;
    return h;
  endfunction

  // Compare outputs at dot position p of line l against the requirements
  task automatic checkPos(input int p, input int l);
    int cw, hk, hgt, kh, vk, cellLines, expAddr, expDot, expLine;
    bit hIn, vIn, expAct, bad;
    string lineTag;
    cw        = dblWidth ? 24 : 12;
    hk        = p - int'(hStart);
    hIn       = (p >= int'(hStart)) && (hk < 24 * cw);
    hgt       = clampHeight(int'(charHeight));
    kh        = dblHeight ? 2 : 1;
    cellLines = hgt * kh;
    vk        = l - int'(vStart);
    vIn       = (l >= int'(vStart)) && (vk < 10 * cellLines);
    expAct    = osdEnable && hIn && vIn;
    bad       = 0;
    checks++;
    if (dispActive !== expAct) begin
      bad = 1;
      $display("FAIL %s R4 R6 R10 dispActive p=%0d l=%0d: actual %0b expected %0b",
               ctx, p, l, dispActive, expAct);
    end
    if (expAct) begin
      expAddr = (vk / cellLines) * 24 + hk / cw;
      expDot  = (hk % cw) / (cw / 12);
      expLine = (((vk % cellLines) / kh) * 18) / hgt;
      lineTag = dblHeight ? "R9" :
                (int'(charHeight) != hgt) ? "R8" : "R7";
      if (ramAddr !== 8'(expAddr)) begin
        bad = 1;
        $display("FAIL %s R11 ramAddr p=%0d l=%0d: actual %0d expected %0d",
                 ctx, p, l, ramAddr, expAddr);
      end
      if (fontDot !== 4'(expDot)) begin
        bad = 1;
        $display("FAIL %s R5 fontDot p=%0d l=%0d: actual %0d expected %0d",
                 ctx, p, l, fontDot, expDot);
      end
      if (fontLine !== 5'(expLine)) begin
        bad = 1;
        $display("FAIL %s %s fontLine p=%0d l=%0d: actual %0d expected %0d",
                 ctx, lineTag, p, l, fontLine, expLine);
      end
    end
    if (bad) errors++;
  endtask

  // One scan line of len clocks; called at a falling edge
  task automatic driveLine(input int len, input bit frame);
    hSyncIn = ~hSyncPol;
    if (frame) vSyncIn = ~vSyncPol;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (i == 4) begin
        hSyncIn = hSyncPol;
        vSyncIn = vSyncPol;
      end
      if (i >= 2) checkPos(i - 2, lineIdx);
    end
  endtask

  task automatic runFrame(input int len, input int nLines);
    lineIdx = 0;
    for (int n = 0; n < nLines; n++) begin
      driveLine(len, n == 0);
      lineIdx++;
    end
  endtask

  // Vertical frame long enough to pass the last row
  task automatic runTallFrame(input int len);
    int rows;
    rows = int'(vStart) + 10 * clampHeight(int'(charHeight)) * (dblHeight ? 2 : 1) + 3;
    runFrame(len, rows);
  endtask

  task automatic mainSeq();
    void'($urandom(32'd7341));
    hSyncPol = 0; vSyncPol = 0; osdEnable = 1;
    hSyncIn = 0; vSyncIn = 0;
    hStart = 11'd37; vStart = 11'd0; charHeight = 7'd18;
    dblHeight = 0; dblWidth = 0;
    rstN = 0;
    repeat (3) @(negedge clk);

    // R1: outputs cleared while reset is held
    checks++;
    if (dispActive !== 1'b0 || ramAddr !== 8'd0 || fontLine !== 5'd0 || fontDot !== 4'd0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %0b/%0d/%0d/%0d expected 0/0/0/0",
               dispActive, ramAddr, fontLine, fontDot);
    end
    rstN = 1;
    repeat (4) @(negedge clk);

    // R3 R4: plain width, large dot offset
    ctx = "R3 R4";
    runFrame(37 + 288 + 15, 3);

    // R5: double width
    ctx = "R5";
    hStart = 11'd5; dblWidth = 1;
    runFrame(5 + 576 + 10, 3);

    // R2: both inputs inverted, zero offset, random width
    ctx = "R2";
    hSyncPol = 1; vSyncPol = 1; hSyncIn = 1; vSyncIn = 1;
    hStart = 11'd0; dblWidth = 1'($urandom_range(0, 1));
    repeat (3) @(negedge clk);
    runFrame(600, 3);
    hStart = 11'($urandom_range(0, 60)); dblWidth = 1'($urandom_range(0, 1));
    runFrame(660, 2);
    hSyncPol = 0; vSyncPol = 0; hSyncIn = 0; vSyncIn = 0;
    repeat (3) @(negedge clk);

    // R10: enable cleared
    ctx = "R10";
    osdEnable = 0; hStart = 11'd10; dblWidth = 0;
    runFrame(320, 2);
    osdEnable = 1;

    // R6 R7: exact minimum height with a line offset
    ctx = "R6 R7";
    hStart = 11'd2; vStart = 11'd3; charHeight = 7'd18;
    runTallFrame(16);

    // R8: heights below and above the range
    ctx = "R8";
    vStart = 11'd0; charHeight = 7'd5;
    runTallFrame(16);
    charHeight = 7'd100;
    runTallFrame(16);

    // R9: double height at maximum and odd height
    ctx = "R9";
    vStart = 11'd2; charHeight = 7'd71; dblHeight = 1;
    runTallFrame(16);
    ctx = "R9 R7";
    vStart = 11'd1; charHeight = 7'd25;
    runTallFrame(16);

    // Seeded random frames mixing all settings
    for (int k = 0; k < 2; k++) begin
      ctx        = "R6 R7 R9";
      charHeight = 7'($urandom_range(18, 71));
      dblHeight  = 1'($urandom_range(0, 1));
      dblWidth   = 1'($urandom_range(0, 1));
      vStart     = 11'($urandom_range(0, 20));
      hStart     = 11'($urandom_range(0, 8));
      runTallFrame(16);
    end
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual hung run, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule